// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Controller

This block is a small accumulator-style processor core. A hardwired state machine is its control unit. The machine keeps a two-bit cycle code that names the current phase: fetch, indirect, execute or interrupt. Inside each phase a step counter walks through timed micro-operations, one per clock. The datapath holds these registers:

- a memory address register
- a memory buffer register
- a program counter
- an instruction register, which keeps the opcode and the address field
- one general register

The core talks to a synchronous single-port memory that returns read data one clock after the read strobe.

The instruction set is deliberately tiny. It has three memory-reference instructions: add to the general register, increment memory and skip when the result is zero, and branch with the return address stored in memory. It also has an interrupt-enable instruction and a halt. A level-sensitive interrupt request is honoured only at the end of an execute phase. Taking it stores the program counter at a fixed location and redirects execution to a fixed handler address.

Top module: `ucyc_core`

## Requirements
- R1: While reset is high, and in the first clock after it falls, the program counter, the general register, `halted` and `irq_ack` are 0. In that first clock `mem_rd` is 1, `mem_addr` is 0 and `mem_wr` is 0.
- R2: Fetch takes three clocks. In the first clock `mem_rd` is high and `mem_addr` equals the program counter. The program counter has advanced by 1 when the third clock begins.
- R3: An instruction word has the indirect flag in bit 15, the opcode in bits 14..12 and the address in bits 11..0. Opcode 0 is add, 1 is increment-skip, 2 is branch-save, 3 is interrupt enable and 7 is halt. Opcodes 4, 5 and 6 change no register or memory and take one execute clock.
- R4: Add sets the general register to its old value plus the memory word at the effective address, modulo 2^16.
- R5: Increment-skip writes the memory word plus 1 back to the same location. When the written value is 0, the program counter advances one extra step, which skips the next instruction.
- R6: Branch-save writes the address of the following instruction, zero-extended, to the effective address X. Execution continues at X+1.
- R7: When bit 15 is set, an indirect phase of three clocks follows fetch. The effective address becomes bits 11..0 of the memory word at the address field, and the upper four bits of that word are ignored.
- R8: An interrupt is taken at the end of an execute phase when `irq` is high and interrupts are enabled. It stores the program counter at address 0 and loads 1 into the program counter. It also clears the enable, pulses `irq_ack` for exactly one clock, and then returns to fetch.
- R9: Interrupts are disabled after reset, so `irq` is ignored until an enable instruction runs. The enable takes effect at the end of that instruction's own execute phase.
- R10: Halt sets `halted` at the end of its execute clock. After that, `mem_rd`, `mem_wr` and `irq_ack` stay low and the program counter stays frozen until reset.
- R11: Phase lengths in clocks are: fetch 3, indirect 3, add 3, increment-skip 4, branch-save 3, any other opcode 1, interrupt 3.
- R12: `mem_rd` and `mem_wr` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_rdata | input | 16 | Read data, valid one clock after the read strobe |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Write data (memory buffer register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| irq_ack | output | 1 | One-clock interrupt acknowledge |
| halted | output | 1 | Core has executed halt |
| pc_o | output | 12 | Program counter |
| gpr_o | output | 16 | General register |

## Verification
Two events can land on the same execute boundary:

- the skip decision of an increment-skip whose result wraps to zero
- the recognition of a pending interrupt

When both happen, the stored return address must already include the skip. The bench provokes this by raising `irq` partway through an increment-skip on a word holding 0xFFFF. It then checks that address 0 holds the address two past that instruction, that exactly one acknowledge was seen, and that the clock on which `halted` rises matches the bench's own phase-length count. Random programs that raise `irq` at random clocks hit the same and other boundaries repeatedly.

// File: rtl/ucyc_pkg.sv
package ucyc_pkg;

    localparam int AW  = 12;
    localparam int DW  = 16;
    localparam int OPW = 3;
    localparam int TW  = 2;

    localparam logic [AW-1:0] SAVE_ADDR = '0;
    localparam logic [AW-1:0] VEC_ADDR  = AW'(1);

    typedef logic [AW-1:0]  addr_t;
    typedef logic [DW-1:0]  word_t;
    typedef logic [OPW-1:0] op_t;
    typedef logic [TW-1:0]  step_t;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_IND   = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INTR  = 2'b11
    } cyc_e;

    localparam op_t OP_ADD = 3'd0;
    localparam op_t OP_ISZ = 3'd1;
    localparam op_t OP_BSA = 3'd2;
    localparam op_t OP_ION = 3'd3;
    localparam op_t OP_HLT = 3'd7;

    typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_ADDR, MAR_SAVE} mar_src_e;
    typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_PC, MBR_INC} mbr_src_e;
    typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_ADDR, PC_VEC, PC_SKIPZ} pc_op_e;

    typedef struct packed {
        mar_src_e mar;
        mbr_src_e mbr;
        pc_op_e   pc;
        logic     ir_ld;
        logic     ir_ind_ld;
        logic     gpr_add;
        logic     rd;
        logic     wr;
    } dp_ctl_t;

    typedef struct packed {
        logic last;
        logic halt;
        logic ion;
        logic ack;
    } seq_ctl_t;

    function automatic word_t pc_to_word(addr_t a);
        return {{(DW-AW){1'b0}}, a};
    endfunction

    function automatic addr_t addr_field(word_t w);
        return w[AW-1:0];
    endfunction

    function automatic op_t op_field(word_t w);
        return w[AW+OPW-1:AW];
    endfunction

endpackage

// File: rtl/ucyc_ctl.sv
module ucyc_ctl
    import ucyc_pkg::*;
(
    input  cyc_e     cyc,
    input  step_t    step,
    input  op_t      op,
    output dp_ctl_t  dc,
    output seq_ctl_t sc
);

    always_comb begin
        dc = '0;
        sc = '0;
        unique case (cyc)
            CYC_FETCH: begin
                case (step)
                    2'd0: begin dc.mar = MAR_PC; dc.rd = 1'b1; end
                    2'd1: begin dc.mbr = MBR_MEM; dc.pc = PC_INC; end
                    default: begin dc.ir_ld = 1'b1; sc.last = 1'b1; end
                endcase
            end
            CYC_IND: begin
                case (step)
                    2'd0: begin dc.mar = MAR_ADDR; dc.rd = 1'b1; end
                    2'd1: dc.mbr = MBR_MEM;
                    default: begin dc.ir_ind_ld = 1'b1; sc.last = 1'b1; end
                endcase
            end
            CYC_EXEC: begin
                case (op)
                    OP_ADD: begin
                        case (step)
                            2'd0: begin dc.mar = MAR_ADDR; dc.rd = 1'b1; end
                            2'd1: dc.mbr = MBR_MEM;
                            default: begin dc.gpr_add = 1'b1; sc.last = 1'b1; end
                        endcase
                    end
                    OP_ISZ: begin
                        case (step)
                            2'd0: begin dc.mar = MAR_ADDR; dc.rd = 1'b1; end
                            2'd1: dc.mbr = MBR_MEM;
                            2'd2: dc.mbr = MBR_INC;
                            default: begin
                                dc.wr = 1'b1;
                                dc.pc = PC_SKIPZ;
                                sc.last = 1'b1;
                            end
                        endcase
                    end
                    OP_BSA: begin
                        case (step)
                            2'd0: begin dc.mar = MAR_ADDR; dc.mbr = MBR_PC; end
                            2'd1: begin dc.pc = PC_ADDR; dc.wr = 1'b1; end
                            default: begin dc.pc = PC_INC; sc.last = 1'b1; end
                        endcase
                    end
                    OP_ION: begin sc.ion = 1'b1; sc.last = 1'b1; end
                    OP_HLT: begin sc.halt = 1'b1; sc.last = 1'b1; end
                    default: sc.last = 1'b1;
                endcase
            end
            default: begin
                case (step)
                    2'd0: begin dc.mbr = MBR_PC; sc.ack = 1'b1; end
                    2'd1: begin dc.mar = MAR_SAVE; dc.pc = PC_VEC; end
                    default: begin dc.wr = 1'b1; sc.last = 1'b1; end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/ucyc_seq.sv
module ucyc_seq
    import ucyc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  last,
    input  logic  halt_req,
    input  logic  ion_req,
    input  logic  irq,
    input  logic  ind_bit,
    output cyc_e  cyc,
    output step_t step,
    output logic  halted
);

    logic ie_q;
    logic ie_eff;
    cyc_e cyc_nx;

    assign ie_eff = ie_q | ion_req;

    always_comb begin
        case (cyc)
            CYC_FETCH: cyc_nx = ind_bit ? CYC_IND : CYC_EXEC;
            CYC_IND:   cyc_nx = CYC_EXEC;
            CYC_EXEC:  cyc_nx = (irq && ie_eff) ? CYC_INTR : CYC_FETCH;
            default:   cyc_nx = CYC_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc    <= CYC_FETCH;
            step   <= '0;
            halted <= 1'b0;
            ie_q   <= 1'b0;
        end else if (!halted) begin
            if (ion_req)
                ie_q <= 1'b1;
            if (halt_req) begin
                halted <= 1'b1;
            end else if (last) begin
                step <= '0;
                cyc  <= cyc_nx;
                if (cyc_nx == CYC_INTR)
                    ie_q <= 1'b0;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ucyc_dp.sv
module ucyc_dp
    import ucyc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  dp_ctl_t dc,
    input  word_t   mem_rdata,
    output addr_t   mem_addr,
    output word_t   mem_wdata,
    output op_t     ir_op,
    output logic    mbr_msb,
    output addr_t   pc,
    output word_t   gpr
);

    addr_t mar_q, mar_nx, ir_addr_q, pc_nx;
    word_t mbr_q, mbr_nx;

    always_comb begin
        case (dc.mar)
            MAR_PC:   mar_nx = pc;
            MAR_ADDR: mar_nx = ir_addr_q;
            MAR_SAVE: mar_nx = SAVE_ADDR;
            default:  mar_nx = mar_q;
        endcase
        case (dc.mbr)
            MBR_MEM: mbr_nx = mem_rdata;
            MBR_PC:  mbr_nx = pc_to_word(pc);
            MBR_INC: mbr_nx = mbr_q + 1'b1;
            default: mbr_nx = mbr_q;
        endcase
        case (dc.pc)
            PC_INC:   pc_nx = pc + 1'b1;
            PC_ADDR:  pc_nx = ir_addr_q;
            PC_VEC:   pc_nx = VEC_ADDR;
            PC_SKIPZ: pc_nx = (mbr_q == '0) ? pc + 1'b1 : pc;
            default:  pc_nx = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q     <= '0;
            mbr_q     <= '0;
            pc        <= '0;
            ir_op     <= '0;
            ir_addr_q <= '0;
            gpr       <= '0;
        end else begin
            mar_q <= mar_nx;
            mbr_q <= mbr_nx;
            pc    <= pc_nx;
            if (dc.ir_ld) begin
                ir_op     <= op_field(mbr_q);
                ir_addr_q <= addr_field(mbr_q);
            end else if (dc.ir_ind_ld) begin
                ir_addr_q <= addr_field(mbr_q);
            end
            if (dc.gpr_add)
                gpr <= gpr + mbr_q;
        end
    end

    assign mem_addr  = dc.rd ? mar_nx : mar_q;
    assign mem_wdata = mbr_q;
    assign mbr_msb   = mbr_q[DW-1];

endmodule

// File: rtl/ucyc_core.sv
module ucyc_core
    import ucyc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          irq,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          irq_ack,
    output logic          halted,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] gpr_o
);

    cyc_e     cyc;
    step_t    step;
    op_t      ir_op;
    logic     mbr_msb;
    dp_ctl_t  dc_raw, dc;
    seq_ctl_t sc;

    ucyc_ctl u_ctl (
        .cyc  (cyc),
        .step (step),
        .op   (ir_op),
        .dc   (dc_raw),
        .sc   (sc)
    );

    ucyc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .last     (sc.last),
        .halt_req (sc.halt),
        .ion_req  (sc.ion),
        .irq      (irq),
        .ind_bit  (mbr_msb),
        .cyc      (cyc),
        .step     (step),
        .halted   (halted)
    );

    assign dc = halted ? '0 : dc_raw;

    ucyc_dp u_dp (
        .clk       (clk),
        .rst       (rst),
        .dc        (dc),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ir_op     (ir_op),
        .mbr_msb   (mbr_msb),
        .pc        (pc_o),
        .gpr       (gpr_o)
    );

    assign mem_rd  = dc.rd;
    assign mem_wr  = dc.wr;
    assign irq_ack = sc.ack & ~halted;

endmodule

// File: rtl/ucyc_chk.sv
module ucyc_chk
    import ucyc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          irq,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          irq_ack,
    input logic          halted,
    input logic [AW-1:0] pc_o
);

    // R12
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    // R8
    ack_after_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> $past(irq));

    // R8
    ack_vector_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> ##1 (pc_o == VEC_ADDR && mem_wr && mem_addr == SAVE_ADDR));

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_rd && !mem_wr && !irq_ack));

    // R10
    halt_pc_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc_o));

endmodule

bind ucyc_core ucyc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .irq_ack  (irq_ack),
    .halted   (halted),
    .pc_o     (pc_o)
);

// File: tb/ucyc_core_tb.sv
module ucyc_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd, mem_wr, irq_ack, halted;
    logic [11:0] pc_o;
    logic [15:0] gpr_o;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [15:0] img [256];
    logic [15:0] mem [256];
    logic [15:0] mm  [256];

    always #10 clk = ~clk;

    ucyc_core u_dut (
        .clk(clk), .rst(rst), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .irq_ack(irq_ack), .halted(halted),
        .pc_o(pc_o), .gpr_o(gpr_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            mem <= img;
        end else begin
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input bit ind, input int op, input int a);
        return {ind, 3'(op), 12'(a)};
    endfunction

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 16'h0;
    endtask

    // Instruction-level model with phase-length accounting (R3..R11)
    task automatic model(input int irq_from, output int e_pc, output int e_gpr,
                         output int e_cyc, output int e_acks);
        int pc = 0, gpr = 0, cyc = 0, acks = 0;
        bit ie = 0, done = 0;
        mm = img;
        while (!done && cyc < 5000) begin
            logic [15:0] w;
            int a, op;
            w = mm[pc % 256];
            pc = (pc + 1) % 4096;
            cyc += 3;
            a = w[11:0];
            if (w[15]) begin
                a = mm[a % 256][11:0];
                cyc += 3;
            end
            op = w[14:12];
            case (op)
                0: begin gpr = (gpr + mm[a % 256]) % 65536; cyc += 3; end
                1: begin
                    mm[a % 256] = mm[a % 256] + 16'd1;
                    if (mm[a % 256] == 16'd0) pc = (pc + 1) % 4096;
                    cyc += 4;
                end
                2: begin mm[a % 256] = 16'(pc); pc = (a + 1) % 4096; cyc += 3; end
                3: begin ie = 1; cyc += 1; end
                7: begin done = 1; cyc += 1; end
                default: cyc += 1;
            endcase
            if (!done && ie && (cyc - 1 >= irq_from)) begin
                mm[0] = 16'(pc);
                pc = 1;
                ie = 0;
                cyc += 3;
                acks++;
            end
        end
        e_pc = pc; e_gpr = gpr; e_cyc = cyc; e_acks = acks;
    endtask

    task automatic run(input string tag, input int irq_from);
        int e_pc, e_gpr, e_cyc, e_acks;
        int n = 0, acks = 0, mis = 0, first = -1;
        model(irq_from, e_pc, e_gpr, e_cyc, e_acks);
        @(negedge clk);
        rst = 1'b1;
        irq = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        irq = (0 >= irq_from);
        if (irq_ack) acks++;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (halted || n > 4000) break;
            irq = (n >= irq_from);
            if (irq_ack) acks++;
        end
        check({tag, " R11 clocks to halt"}, n, e_cyc);
        check({tag, " R10 pc"}, pc_o, e_pc);
        check({tag, " R4 gpr"}, gpr_o, e_gpr);
        check({tag, " R8 acks"}, acks, e_acks);
        for (int i = 0; i < 256; i++)
            if (mem[i] !== mm[i]) begin
                mis++;
                if (first < 0) first = i;
            end
        if (first >= 0)
            $display("mem[%0h] act=%0h exp=%0h", first, mem[first], mm[first]);
        check({tag, " R5/R6 memory mismatches"}, mis, 0);
    endtask

    // Common prologue: 0 branch-save to 0x0F (continue at 0x10), 1 halt (handler)
    task automatic prologue();
        clear_img();
        img[0] = ins(0, 2, 12'h00F);
        img[1] = ins(0, 7, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            bad++;
            total++;
            $display("FAIL watchdog act=expired exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));

        // R1 / R2: reset state and first fetch
        clear_img();
        img[0] = ins(0, 7, 0);
        repeat (3) @(negedge clk);
        check("R1 pc in reset", pc_o, 0);
        check("R1 gpr in reset", gpr_o, 0);
        check("R1 halted in reset", halted, 0);
        check("R1 ack in reset", irq_ack, 0);
        rst = 1'b0;
        check("R1 first rd", mem_rd, 1);
        check("R1 first addr", mem_addr, 0);
        check("R1 first wr", mem_wr, 0);
        @(posedge clk); @(negedge clk);
        check("R2 t2 no rd", mem_rd, 0);
        @(posedge clk); @(negedge clk);
        check("R2 pc advanced", pc_o, 1);

        // R3 / R4: add with an undefined opcode between
        clear_img();
        img[0] = ins(0, 0, 12'h080);
        img[1] = ins(0, 5, 12'h081);
        img[2] = ins(0, 0, 12'h081);
        img[3] = ins(0, 7, 0);
        img[8'h80] = 16'h1234;
        img[8'h81] = 16'hF000;
        run("add R3", 100000);

        // R5: wrap and skip, then a plain increment
        clear_img();
        img[0] = ins(0, 1, 12'h080);
        img[1] = ins(0, 7, 0);
        img[2] = ins(0, 1, 12'h081);
        img[3] = ins(0, 7, 0);
        img[8'h80] = 16'hFFFF;
        img[8'h81] = 16'h0005;
        run("isz R5", 100000);

        // R6: branch-save and subroutine body
        clear_img();
        img[0] = ins(0, 0, 12'h080);
        img[1] = ins(0, 2, 12'h020);
        img[8'h21] = ins(0, 0, 12'h080);
        img[8'h22] = ins(0, 7, 0);
        img[8'h80] = 16'h0101;
        run("bsa R6", 100000);

        // R7: indirect add and indirect branch, upper pointer bits ignored
        clear_img();
        img[0] = ins(1, 0, 12'h090);
        img[1] = ins(1, 2, 12'h091);
        img[8'h31] = ins(1, 1, 12'h090);
        img[8'h32] = ins(0, 7, 0);
        img[8'h80] = 16'h4321;
        img[8'h90] = 16'hF080;
        img[8'h91] = 16'hA030;
        run("ind R7", 100000);

        // R9: irq held high without enable is ignored
        prologue();
        img[8'h10] = ins(0, 0, 12'h080);
        img[8'h11] = ins(0, 4, 0);
        img[8'h12] = ins(0, 0, 12'h081);
        img[8'h13] = ins(0, 7, 0);
        img[8'h80] = 16'h0011;
        img[8'h81] = 16'h0022;
        run("noen R9", 0);

        // R8 / R9: enable taken at the end of its own execute
        prologue();
        img[8'h10] = ins(0, 0, 12'h080);
        img[8'h11] = ins(0, 3, 0);
        img[8'h12] = ins(0, 0, 12'h081);
        img[8'h13] = ins(0, 7, 0);
        img[8'h80] = 16'h0011;
        img[8'h81] = 16'h0022;
        run("irq R8", 0);
        check("R8 saved return", mem[0], 16'h0012);

        // R5 + R8 same boundary: irq rises inside a wrapping increment-skip
        prologue();
        img[8'h10] = ins(0, 3, 0);
        img[8'h11] = ins(0, 1, 12'h080);
        img[8'h12] = ins(0, 7, 0);
        img[8'h13] = ins(0, 7, 0);
        img[8'h80] = 16'hFFFF;
        run("skip+irq R8", 14);
        check("R5 R8 saved past skip", mem[0], 16'h0013);

        // Random programs (R3..R11)
        for (int t = 0; t < 40; t++) begin
            int from;
            prologue();
            for (int k = 0; k < 8; k++) begin
                int r, j;
                bit ind;
                r = $urandom % 4;
                j = $urandom % 8;
                ind = ($urandom % 3) == 0;
                case (r)
                    0: img[8'h10 + k] = ins(ind, 0, ind ? 12'h090 + j : 12'h080 + j);
                    1: img[8'h10 + k] = ins(ind, 1, ind ? 12'h090 + j : 12'h080 + j);
                    2: img[8'h10 + k] = ins(0, 3, 0);
                    default: img[8'h10 + k] = ins(0, 4 + ($urandom % 3), j);
                endcase
            end
            img[8'h18] = ins(0, 7, 0);
            img[8'h19] = ins(0, 7, 0);
            for (int j = 0; j < 8; j++) begin
                img[8'h80 + j] = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom);
                img[8'h90 + j] = {4'($urandom), 12'h080 + 12'(j)};
            end
            from = ($urandom % 2) ? int'($urandom % 150) : 100000;
            run("random", from);
        end

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule